// File: doc/BRIEF.md
# Two-Thread Partitioned L2 Tag Controller

This block keeps the tags, the per-sub-block valid bits and the replacement state for an external second-level cache that two hardware threads share. Each thread has a tag store of its own and sees a private half of one physical data array. The thread number drives the most significant bit of the data-array address. Each set holds two ways. A request carries a physical address and a read/write flag. One cycle after the request is accepted, the block reports four things: whether the line and the addressed sub-block are present, which way is involved, the valid bits of that way, and the data-array address to drive.

On a miss, the reported way is the one a fill must go to. The surrounding logic fetches the line and hands it back through the fill port. A mode input selects one of two line formats:

- **Long mode:** 128-byte lines built from two 64-byte sub-blocks.
- **Short mode:** 64-byte lines with no sub-blocking, which halves each thread's capacity.

Both threads share the tag port, so at most one lookup is accepted per cycle. Requests use valid/ready:

- A thread raises valid with its address and write flag, and holds all three unchanged until it sees ready high at a clock edge.
- Ready may depend on the valid inputs and on the fill port.
- The fill port also uses valid/ready. Its ready drops only while the tag stores are being cleared after a change of line mode.

Top module: `l2t_ctl`

## Requirements
- R1: A response appears with `rsp_valid` high in the cycle after a request is accepted. `rsp_hit` is 1 when the thread's tag store holds the line and its addressed sub-block is valid. The response also gives `rsp_way`, the valid bits of that way in `rsp_sub_valid` (bit 0 for the lower 64 bytes), and the request's write flag in `rsp_write`. `rsp_hit` and `rsp_sub_miss` are never both 1.
- R2: Each thread has its own tag store; a line filled for one thread is never reported as present for the other. `rsp_array_addr` is laid out as {thread, way, set index, sub-block}, with the thread in the top bit.
- R3: In long mode, address bit 6 selects the sub-block, bits [7 +: SET_W] give the set index, and the bits above them form the tag.
- R4: A lookup whose tag matches a way whose addressed sub-block is invalid reports `rsp_sub_miss`=1, `rsp_hit`=0, and that way's number and valid bits. A fill of that sub-block into the same way and tag sets its valid bit and keeps the other.
- R5: On a full miss, `rsp_way` names the victim: way 0 if it holds no valid sub-block, otherwise way 1 if it holds none, otherwise the way marked least recently used.
- R6: Each set keeps one LRU bit per thread. A hit or a fill marks the other way as least recently used. A miss or a sub-block miss leaves the bit unchanged.
- R7: In short mode, bits [6 +: SET_W] give the set index, the bits above them form the tag, the sub-block field of `rsp_array_addr` is 0, and a filled line shows `rsp_sub_valid`=01.
- R8: When `line_mode` differs from the mode in force, the block takes no lookups and no fills for 2**SET_W+1 cycles. It then continues with every entry of both threads invalid.
- R9: If both threads request in the same cycle, only one is accepted. The two take turns, thread 0 goes first after reset, and the waiting thread keeps valid until it is accepted.
- R10: A fill has priority: while `fill_valid` is high, no lookup is accepted. `fill_ready` is high at all times except during a mode change.
- R11: After reset, `rsp_valid` is 0, `fill_ready` is 1 and every entry is invalid.
- R12: `rsp_valid` is high exactly in the cycle after each accepted lookup and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_mode | input | 1 | 0 = 128-byte sub-blocked lines, 1 = 64-byte lines |
| t0_req_valid | input | 1 | Thread 0 lookup request valid |
| t0_req_ready | output | 1 | Thread 0 lookup accepted this cycle |
| t0_req_addr | input | PA_W | Thread 0 physical address |
| t0_req_write | input | 1 | Thread 0 write flag |
| t1_req_valid | input | 1 | Thread 1 lookup request valid |
| t1_req_ready | output | 1 | Thread 1 lookup accepted this cycle |
| t1_req_addr | input | PA_W | Thread 1 physical address |
| t1_req_write | input | 1 | Thread 1 write flag |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_thread | output | 1 | Thread of the result |
| rsp_write | output | 1 | Write flag of the request |
| rsp_hit | output | 1 | Line and addressed sub-block present |
| rsp_sub_miss | output | 1 | Tag present, addressed sub-block invalid |
| rsp_way | output | 1 | Hit way, or victim way on a miss |
| rsp_sub_valid | output | 2 | Sub-block valid bits of `rsp_way` (00 on a full miss) |
| rsp_array_addr | output | SET_W+3 | Data-array address {thread, way, set, sub-block} |
| fill_valid | input | 1 | Fill request valid |
| fill_ready | output | 1 | Fill accepted when high with `fill_valid` |
| fill_thread | input | 1 | Thread owning the fill |
| fill_addr | input | PA_W | Address of the filled sub-block or line |
| fill_way | input | 1 | Way to write |

## Verification
The bench builds the block with PA_W=16 and SET_W=2. With only four sets, distinct tags are easy to aim at a single set, so the invalid-way victim choice, LRU aging and a sub-block miss can all be driven into the same set in a few requests. The small set count also keeps the mode-change clear short: its exact stall length can be counted cycle by cycle, and a round trip through both line modes is cheap to run. The 16-bit address holds an eight-bit tag in short mode, so the different bit splits of the two modes show up directly in `rsp_array_addr`.

// File: rtl/l2t_pkg.sv
package l2t_pkg;
  localparam int SUBS    = 2;   // sub-blocks per long line
  localparam int SUB_LOG = 6;   // log2 of sub-block bytes

  typedef enum logic {LM_LONG = 1'b0, LM_SHORT = 1'b1} line_mode_e;
  typedef enum logic {SQ_RUN = 1'b0, SQ_CLEAR = 1'b1} seq_state_e;

  function automatic logic [SUBS-1:0] sub_onehot(input logic sub);
    return sub ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/l2t_addr_split.sv
module l2t_addr_split
  import l2t_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int SET_W = 6,
  parameter int STW   = PA_W - SUB_LOG - SET_W
) (
  input  logic [PA_W-1:0]  addr,
  input  line_mode_e       mode,
  output logic [SET_W-1:0] idx,
  output logic [STW-1:0]   tag,
  output logic             sub
);
  localparam int SHORT_OFS = SUB_LOG;
  localparam int LONG_OFS  = SUB_LOG + 1;

  always_comb begin
    if (mode == LM_SHORT) begin
      idx = addr[SHORT_OFS +: SET_W];
      tag = STW'(addr >> (SHORT_OFS + SET_W));
      sub = 1'b0;
    end else begin
      idx = addr[LONG_OFS +: SET_W];
      tag = STW'(addr >> (LONG_OFS + SET_W));
      sub = addr[SHORT_OFS];
    end
  end
endmodule

// File: rtl/l2t_rr_arb.sv
module l2t_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       avail,
  output logic [1:0] gnt
);
  logic last_q;   // thread granted most recently

  always_comb begin
    gnt = 2'b00;
    if (avail) begin
      if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
      else              gnt = req;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (|gnt) last_q <= gnt[1];
  end
endmodule

// File: rtl/l2t_mode_seq.sv
module l2t_mode_seq
  import l2t_pkg::*;
#(
  parameter int SET_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_mode,
  output line_mode_e       mode_q,
  output logic             busy,
  output logic             clr_en,
  output logic [SET_W-1:0] clr_idx
);
  localparam int unsigned LAST = (2 ** SET_W) - 1;

  seq_state_e       st_q;
  line_mode_e       tgt_q;
  logic [SET_W-1:0] cnt_q;
  line_mode_e       want;

  assign want = line_mode_e'(line_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= SQ_RUN;
      mode_q <= LM_LONG;
      tgt_q  <= LM_LONG;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        SQ_RUN: if (want != mode_q) begin
          st_q  <= SQ_CLEAR;
          tgt_q <= want;
          cnt_q <= '0;
        end
        SQ_CLEAR: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == SET_W'(LAST)) begin
            st_q   <= SQ_RUN;
            mode_q <= tgt_q;
          end
        end
        default: st_q <= SQ_RUN;
      endcase
    end
  end

  assign clr_en  = (st_q == SQ_CLEAR);
  assign clr_idx = cnt_q;
  assign busy    = clr_en | (want != mode_q);
endmodule

// File: rtl/l2t_tag_bank.sv
module l2t_tag_bank
  import l2t_pkg::*;
#(
  parameter int SET_W = 6,
  parameter int STW   = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [SET_W-1:0] lk_idx,
  input  logic [STW-1:0]   lk_tag,
  input  logic             lk_sub,
  output logic             lk_hit,
  output logic             lk_sub_miss,
  output logic             lk_way,
  output logic [SUBS-1:0]  lk_vld,
  input  logic             fl_en,
  input  logic [SET_W-1:0] fl_idx,
  input  logic [STW-1:0]   fl_tag,
  input  logic             fl_sub,
  input  logic             fl_way,
  input  logic             clr_en,
  input  logic [SET_W-1:0] clr_idx
);
  localparam int SETS = 2 ** SET_W;
  localparam int WAYS = 2;

  logic [STW-1:0]  tag_q [SETS][WAYS];
  logic [SUBS-1:0] vld_q [SETS][WAYS];
  logic [SETS-1:0] lru_q;

  logic [WAYS-1:0] match;
  logic            victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = (|vld_q[lk_idx][w]) && (tag_q[lk_idx][w] == lk_tag);
  end

  always_comb begin
    if (vld_q[lk_idx][0] == '0)      victim = 1'b0;
    else if (vld_q[lk_idx][1] == '0) victim = 1'b1;
    else                             victim = lru_q[lk_idx];
  end

  always_comb begin
    if (match[0])      lk_way = 1'b0;
    else if (match[1]) lk_way = 1'b1;
    else               lk_way = victim;
    lk_vld      = (|match) ? vld_q[lk_idx][lk_way] : '0;
    lk_hit      = (|match) &&  lk_vld[lk_sub];
    lk_sub_miss = (|match) && !lk_vld[lk_sub];
  end

  // merge of a fill with what the way already holds for the same tag
  logic [SUBS-1:0] fl_old, fl_new;
  logic            fl_same;
  always_comb begin
    fl_old  = vld_q[fl_idx][fl_way];
    fl_same = (|fl_old) && (tag_q[fl_idx][fl_way] == fl_tag);
    fl_new  = (fl_same ? fl_old : '0) | sub_onehot(fl_sub);
  end

  always_ff @(posedge clk) begin
    if (fl_en) tag_q[fl_idx][fl_way] <= fl_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) vld_q[s][w] <= '0;
      end
      lru_q <= '0;
    end else if (clr_en) begin
      for (int w = 0; w < WAYS; w++) vld_q[clr_idx][w] <= '0;
      lru_q[clr_idx] <= 1'b0;
    end else begin
      if (fl_en) begin
        vld_q[fl_idx][fl_way] <= fl_new;
        lru_q[fl_idx]         <= ~fl_way;
      end
      if (lk_en && lk_hit) lru_q[lk_idx] <= ~lk_way;
    end
  end
endmodule

// File: rtl/l2t_ctl.sv
module l2t_ctl
  import l2t_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int SET_W = 6,
  localparam int STW  = PA_W - SUB_LOG - SET_W,
  localparam int AA_W = SET_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_mode,
  input  logic             t0_req_valid,
  output logic             t0_req_ready,
  input  logic [PA_W-1:0]  t0_req_addr,
  input  logic             t0_req_write,
  input  logic             t1_req_valid,
  output logic             t1_req_ready,
  input  logic [PA_W-1:0]  t1_req_addr,
  input  logic             t1_req_write,
  output logic             rsp_valid,
  output logic             rsp_thread,
  output logic             rsp_write,
  output logic             rsp_hit,
  output logic             rsp_sub_miss,
  output logic             rsp_way,
  output logic [SUBS-1:0]  rsp_sub_valid,
  output logic [AA_W-1:0]  rsp_array_addr,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic             fill_thread,
  input  logic [PA_W-1:0]  fill_addr,
  input  logic             fill_way
);
  line_mode_e       mode_q;
  logic             busy, clr_en;
  logic [SET_W-1:0] clr_idx;

  l2t_mode_seq #(.SET_W(SET_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode), .mode_q(mode_q),
    .busy(busy), .clr_en(clr_en), .clr_idx(clr_idx)
  );

  logic fill_fire, avail;
  logic [1:0] gnt;
  assign fill_ready = !busy;
  assign fill_fire  = fill_valid && fill_ready;
  assign avail      = !busy && !fill_valid;

  l2t_rr_arb u_arb (
    .clk(clk), .rst_n(rst_n), .req({t1_req_valid, t0_req_valid}),
    .avail(avail), .gnt(gnt)
  );
  assign t0_req_ready = gnt[0];
  assign t1_req_ready = gnt[1];

  logic            lk_thr, lk_fire;
  logic [PA_W-1:0] lk_addr;
  assign lk_thr  = gnt[1];
  assign lk_fire = |gnt;
  assign lk_addr = lk_thr ? t1_req_addr : t0_req_addr;

  logic [SET_W-1:0] lk_idx, fl_idx;
  logic [STW-1:0]   lk_tag, fl_tag;
  logic             lk_sub, fl_sub;

  l2t_addr_split #(.PA_W(PA_W), .SET_W(SET_W), .STW(STW)) u_lk_split (
    .addr(lk_addr), .mode(mode_q), .idx(lk_idx), .tag(lk_tag), .sub(lk_sub)
  );
  l2t_addr_split #(.PA_W(PA_W), .SET_W(SET_W), .STW(STW)) u_fl_split (
    .addr(fill_addr), .mode(mode_q), .idx(fl_idx), .tag(fl_tag), .sub(fl_sub)
  );

  logic [1:0]      b_hit, b_sm, b_way;
  logic [SUBS-1:0] b_vld [2];

  for (genvar t = 0; t < 2; t++) begin : g_thr
    l2t_tag_bank #(.SET_W(SET_W), .STW(STW)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .lk_en(gnt[t]), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_sub(lk_sub),
      .lk_hit(b_hit[t]), .lk_sub_miss(b_sm[t]), .lk_way(b_way[t]),
      .lk_vld(b_vld[t]),
      .fl_en(fill_fire && (fill_thread == 1'(t))), .fl_idx(fl_idx),
      .fl_tag(fl_tag), .fl_sub(fl_sub), .fl_way(fill_way),
      .clr_en(clr_en), .clr_idx(clr_idx)
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid      <= 1'b0;
      rsp_thread     <= 1'b0;
      rsp_write      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_sub_miss   <= 1'b0;
      rsp_way        <= 1'b0;
      rsp_sub_valid  <= '0;
      rsp_array_addr <= '0;
    end else begin
      rsp_valid <= lk_fire;
      if (lk_fire) begin
        rsp_thread     <= lk_thr;
        rsp_write      <= lk_thr ? t1_req_write : t0_req_write;
        rsp_hit        <= b_hit[lk_thr];
        rsp_sub_miss   <= b_sm[lk_thr];
        rsp_way        <= b_way[lk_thr];
        rsp_sub_valid  <= b_vld[lk_thr];
        rsp_array_addr <= {lk_thr, b_way[lk_thr], lk_idx, lk_sub};
      end
    end
  end
endmodule

// File: rtl/l2t_ctl_chk.sv
module l2t_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic line_mode,
  input logic t0_req_valid,
  input logic t0_req_ready,
  input logic t1_req_valid,
  input logic t1_req_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_sub_miss,
  input logic fill_valid,
  input logic fill_ready
);
  logic t0f, t1f;
  assign t0f = t0_req_valid && t0_req_ready;
  assign t1f = t1_req_valid && t1_req_ready;

  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(t0f && t1f));
  p_turn_t1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (t0f && t1_req_valid) |=> !t0_req_ready);
  p_turn_t0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (t1f && t0_req_valid) |=> !t1_req_ready);
  p_rsp_after_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (t0f || t1f) |=> rsp_valid);
  p_rsp_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(t0f || t1f) |=> !rsp_valid);
  p_hit_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_hit && rsp_sub_miss));
  p_fill_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> (!t0_req_ready && !t1_req_ready));
  p_mode_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$stable(line_mode)) |->
      (!t0_req_ready && !t1_req_ready && !fill_ready));
endmodule

bind l2t_ctl l2t_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .line_mode(line_mode),
  .t0_req_valid(t0_req_valid), .t0_req_ready(t0_req_ready),
  .t1_req_valid(t1_req_valid), .t1_req_ready(t1_req_ready),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_sub_miss(rsp_sub_miss),
  .fill_valid(fill_valid), .fill_ready(fill_ready)
);

// File: tb/test_l2t_ctl.sv
`timescale 1ns/1ps
module test_l2t_ctl;
  localparam int PA_W = 16;
  localparam int SET_W = 2;
  localparam int AA_W = SET_W + 3;

  logic clk = 1'b0;
  logic rst_n, line_mode;
  logic t0_req_valid, t0_req_ready, t0_req_write;
  logic t1_req_valid, t1_req_ready, t1_req_write;
  logic [PA_W-1:0] t0_req_addr, t1_req_addr, fill_addr;
  logic rsp_valid, rsp_thread, rsp_write, rsp_hit, rsp_sub_miss, rsp_way;
  logic [1:0] rsp_sub_valid;
  logic [AA_W-1:0] rsp_array_addr;
  logic fill_valid, fill_ready, fill_thread, fill_way;

  always #5 clk = ~clk;

  l2t_ctl #(.PA_W(PA_W), .SET_W(SET_W)) i_l2t_ctl (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode),
    .t0_req_valid(t0_req_valid), .t0_req_ready(t0_req_ready),
    .t0_req_addr(t0_req_addr), .t0_req_write(t0_req_write),
    .t1_req_valid(t1_req_valid), .t1_req_ready(t1_req_ready),
    .t1_req_addr(t1_req_addr), .t1_req_write(t1_req_write),
    .rsp_valid(rsp_valid), .rsp_thread(rsp_thread), .rsp_write(rsp_write),
    .rsp_hit(rsp_hit), .rsp_sub_miss(rsp_sub_miss), .rsp_way(rsp_way),
    .rsp_sub_valid(rsp_sub_valid), .rsp_array_addr(rsp_array_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_thread(fill_thread), .fill_addr(fill_addr), .fill_way(fill_way)
  );

  int checks = 0;
  int fails  = 0;

  // {kind(1=fill), thr, addr[15:0], wr, fill_way, hit, sub_miss, way, sub_valid[1:0], array_addr[4:0]}
  // long mode: tag = addr>>9, set = addr[8:7], sub = addr[6]
  // R1 hits, R2 thread split, R4 sub-block miss/fill, R5 victim, R6 LRU aging
  localparam logic [29:0] VEC [16] = '{
    {1'b0,1'b0,16'h0A80,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd2},
    {1'b1,1'b0,16'h0A80,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd0},
    {1'b0,1'b0,16'h0A80,1'b1,1'b0, 1'b1,1'b0,1'b0,2'b01,5'd2},
    {1'b0,1'b0,16'h0AC0,1'b0,1'b0, 1'b0,1'b1,1'b0,2'b01,5'd3},
    {1'b1,1'b0,16'h0AC0,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd0},
    {1'b0,1'b0,16'h0AC0,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b11,5'd3},
    {1'b0,1'b1,16'h0A80,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd18},
    {1'b0,1'b0,16'h1280,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00,5'd10},
    {1'b1,1'b0,16'h1280,1'b0,1'b1, 1'b0,1'b0,1'b0,2'b00,5'd0},
    {1'b0,1'b0,16'h1880,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd2},
    {1'b0,1'b0,16'h0A80,1'b0,1'b0, 1'b1,1'b0,1'b0,2'b11,5'd2},
    {1'b0,1'b0,16'h1880,1'b0,1'b0, 1'b0,1'b0,1'b1,2'b00,5'd10},
    {1'b0,1'b0,16'h1280,1'b1,1'b0, 1'b1,1'b0,1'b1,2'b01,5'd10},
    {1'b0,1'b0,16'h1880,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd2},
    {1'b0,1'b0,16'h0B00,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd4},
    {1'b0,1'b1,16'h1280,1'b0,1'b0, 1'b0,1'b0,1'b0,2'b00,5'd18}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic thr, input logic [PA_W-1:0] a, input logic wr);
    int guard;
    if (thr) begin t1_req_valid = 1'b1; t1_req_addr = a; t1_req_write = wr; end
    else     begin t0_req_valid = 1'b1; t0_req_addr = a; t0_req_write = wr; end
    #1;
    guard = 0;
    while (!(thr ? t1_req_ready : t0_req_ready) && guard < 50) begin
      @(negedge clk); #1; guard++;
    end
    @(posedge clk); #1;
    t0_req_valid = 1'b0; t1_req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic fill(input logic thr, input logic [PA_W-1:0] a, input logic w);
    fill_valid = 1'b1; fill_thread = thr; fill_addr = a; fill_way = w;
    @(posedge clk); #1;
    fill_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic rsp_chk(input string req, input logic thr, input logic eh,
                         input logic esm, input logic ew, input logic [1:0] esv,
                         input logic [AA_W-1:0] eaa);
    chk(req, "rsp_valid", rsp_valid, 1);
    chk(req, "rsp_thread", rsp_thread, thr);
    chk(req, "rsp_hit", rsp_hit, eh);
    chk(req, "rsp_sub_miss", rsp_sub_miss, esm);
    chk(req, "rsp_way", rsp_way, ew);
    chk(req, "rsp_sub_valid", rsp_sub_valid, esv);
    chk(req, "rsp_array_addr", rsp_array_addr, eaa);
  endtask

  logic [29:0] v;
  int stall;

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; line_mode = 1'b0;
    t0_req_valid = 0; t0_req_addr = '0; t0_req_write = 0;
    t1_req_valid = 0; t1_req_addr = '0; t1_req_write = 0;
    fill_valid = 0; fill_thread = 0; fill_addr = '0; fill_way = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11", "rsp_valid after reset", rsp_valid, 0);
    chk("R11", "fill_ready after reset", fill_ready, 1);
    chk("R11", "t0 ready idle", t0_req_ready, 0);
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      v = VEC[i];
      if (v[29]) fill(v[28], v[27:12], v[10]);
      else begin
        lookup(v[28], v[27:12], v[11]);
        chk("R1", "rsp_write", rsp_write, v[11]);
        chk("R1", "rsp_hit", rsp_hit, v[9]);
        chk("R4", "rsp_sub_miss", rsp_sub_miss, v[8]);
        chk("R5 R6", "rsp_way", rsp_way, v[7]);
        chk("R4", "rsp_sub_valid", rsp_sub_valid, v[6:5]);
        chk("R2 R3", "rsp_array_addr", rsp_array_addr, v[4:0]);
      end
    end

    // R9: contention, thread 1 was granted last so thread 0 goes first
    t0_req_valid = 1; t0_req_addr = 16'h0A80; t0_req_write = 0;
    t1_req_valid = 1; t1_req_addr = 16'h0A80; t1_req_write = 0;
    #1;
    chk("R9", "t0 ready in contention", t0_req_ready, 1);
    chk("R9", "t1 held", t1_req_ready, 0);
    @(posedge clk); #1; t0_req_valid = 0;
    @(negedge clk);
    rsp_chk("R9", 1'b0, 1, 0, 0, 2'b11, 5'd2);
    chk("R9", "t1 ready next turn", t1_req_ready, 1);
    @(posedge clk); #1; t1_req_valid = 0;
    @(negedge clk);
    rsp_chk("R9", 1'b1, 0, 0, 0, 2'b00, 5'd18);

    // R10: fill blocks a lookup in the same cycle
    t0_req_valid = 1; t0_req_addr = 16'h0A80;
    fill_valid = 1; fill_thread = 1; fill_addr = 16'h0A80; fill_way = 0;
    #1;
    chk("R10", "t0 ready during fill", t0_req_ready, 0);
    chk("R10", "fill_ready", fill_ready, 1);
    @(posedge clk); #1; fill_valid = 0;
    @(negedge clk);
    chk("R12", "no rsp after blocked cycle", rsp_valid, 0);
    chk("R10", "t0 ready after fill", t0_req_ready, 1);
    @(posedge clk); #1; t0_req_valid = 0;
    @(negedge clk);
    rsp_chk("R10", 1'b0, 1, 0, 0, 2'b11, 5'd2);
    lookup(1'b1, 16'h0A80, 1'b0);
    rsp_chk("R2", 1'b1, 1, 0, 0, 2'b01, 5'd18);

    // R11: reset mid-run clears every entry
    rst_n = 0; @(negedge clk); rst_n = 1;
    lookup(1'b0, 16'h0A80, 1'b0);
    rsp_chk("R11", 1'b0, 0, 0, 0, 2'b00, 5'd2);

    // R8: change to short mode, count stalled cycles
    line_mode = 1; t0_req_valid = 1; t0_req_addr = 16'h0A80; t0_req_write = 0;
    #1;
    chk("R8", "fill_ready during clear", fill_ready, 0);
    stall = 0;
    while (!t0_req_ready && stall < 100) begin
      stall++; @(negedge clk); #1;
    end
    chk("R8", "stall cycles", stall, (2 ** SET_W) + 1);
    @(posedge clk); #1; t0_req_valid = 0;
    @(negedge clk);
    rsp_chk("R7", 1'b0, 0, 0, 0, 2'b00, 5'd4);

    // R7: short mode, set = addr[7:6], no sub-blocks
    fill(1'b0, 16'h0A80, 1'b0);
    lookup(1'b0, 16'h0AC0, 1'b0);
    rsp_chk("R7", 1'b0, 0, 0, 0, 2'b00, 5'd6);
    lookup(1'b0, 16'h0A80, 1'b0);
    rsp_chk("R7", 1'b0, 1, 0, 0, 2'b01, 5'd4);
    fill(1'b1, 16'h0A80, 1'b1);
    lookup(1'b1, 16'h0A80, 1'b0);
    rsp_chk("R7", 1'b1, 1, 0, 1, 2'b01, 5'd28);

    // R8: round trip through long mode invalidates both threads
    line_mode = 0; repeat (8) @(negedge clk);
    line_mode = 1; repeat (8) @(negedge clk);
    lookup(1'b0, 16'h0A80, 1'b0);
    rsp_chk("R8", 1'b0, 0, 0, 0, 2'b00, 5'd4);
    lookup(1'b1, 16'h0A80, 1'b0);
    rsp_chk("R8", 1'b1, 0, 0, 0, 2'b00, 5'd20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule